// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block sits beside a processor core and decides which interrupt the core takes next. Six maskable levels each keep a pending flag and an enable bit. One further request line is non-maskable. A request pulse on a level latches its flag. The flag stays set until software clears it or until the level is taken. A single global disable bit gates every maskable level at once. It reads 1 after reset, so software must clear it before any maskable level can be taken.

The chosen interrupt goes to the core on a valid/ready pair. `irq_valid` stays high for as long as something is eligible, and `irq_vector` carries the address to branch to. The core accepts the offer by raising `irq_ready`. A cycle with both high is the acknowledge. At that clock edge the taken level's flag is cleared and the global disable bit is set. While the core holds `irq_ready` low, the offer waits. It is withdrawn only by a software write to the flags, the enables or the disable bit. A request of higher priority that arrives while the offer waits replaces the vector.

Software reaches the flag register, the enable register and the disable bit through a small register port with a select, a write strobe and a combinational read. Nested interrupts happen only when a service routine clears the disable bit again.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset all six flags read 0, the global disable bit reads 1 and `irq_valid` is 0.
- R2: A 1 on `lvl_req[i]` at a clock edge sets flag bit i, which stands for level i+1. The flag reads 1 from the next cycle and holds until cleared.
- R3: A register write with `reg_sel`=0 clears each flag whose `reg_wdata` bit is 1 and leaves the other flags alone. If a request for the same level arrives in the same cycle, that flag stays 1.
- R4: The enable register is at `reg_sel`=1, bits 5:0. A 1 enables the level and a 0 blocks it. The register keeps its contents through reset.
- R5: A maskable level is offered (`irq_valid`=1 with `irq_nmi`=0) only when its flag is 1, its enable is 1 and the global disable bit is 0.
- R6: When several levels are eligible, the lowest-numbered one is offered, so level 1 beats level 6.
- R7: The vector of a maskable level is twice its level number: level 1 gives 0x02, level 3 gives 0x06 and level 6 gives 0x0C.
- R8: At an acknowledge edge the taken level's flag clears, unless a request for that level arrives in the same cycle. While `irq_ready` is 0 and software writes nothing, `irq_valid` stays 1.
- R9: Every acknowledge, maskable or not, sets the global disable bit. This wins over a software write to that bit in the same cycle.
- R10: A write with `reg_sel`=2 loads `reg_wdata[0]` into the global disable bit, and a read of select 2 returns it in bit 0. Clearing the bit inside a service routine lets a pending level be offered again, which gives nesting.
- R11: A pulse on `nmi_req` is latched and offered with `irq_nmi`=1 and vector 0x24. The offer does not depend on the enables or the global disable bit, and it takes priority over all levels. Its acknowledge clears only the non-maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_req | input | 6 | Request pulse per level; bit i is level i+1 |
| nmi_req | input | 1 | Non-maskable request pulse |
| reg_sel | input | 2 | Register select: 0 flags, 1 enables, 2 global disable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read of the selected register |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_ready | input | 1 | The core accepts the offer |
| irq_nmi | output | 1 | The offer is the non-maskable request |
| irq_vector | output | 8 | Branch address of the offer |

## Verification
Two pairs of actions can land in the same cycle. The first is a level's new request together with the clearing of that same flag, whether the clear comes from a software write of 1 or from an acknowledge. The second is an acknowledge together with a software write that clears the global disable bit. The bench drives each pair on one clock edge and then reads the flag register and the disable bit back through the register port. The request must keep its flag and the acknowledge must leave the disable bit set. A non-maskable pulse is also raised in the same cycle as a level request, to show that the non-maskable request is offered first and that the level's flag survives.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_MASK = 2'd1,
    SEL_GDIS = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int LVL_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-1:0] set_vec,
  input  logic [LVL_N-1:0] clr_vec,
  output logic [LVL_N-1:0] flag_q
);

  // a fresh request outranks any clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int LVL_N = 6,
  parameter int VEC_W = 8,
  localparam int NUM_W = $clog2(LVL_N + 1)
) (
  input  logic [LVL_N-1:0] elig,
  output logic [LVL_N-1:0] grant_oh,
  output logic             any,
  output logic [VEC_W-1:0] lvl_vec
);

  logic [LVL_N:0]   higher;
  logic [NUM_W-1:0] lvl_num;

  assign higher[0] = 1'b0;

  for (genvar g = 0; g < LVL_N; g++) begin : g_chain
    assign grant_oh[g]   = elig[g] & ~higher[g];
    assign higher[g + 1] = higher[g] | elig[g];
  end

  assign any = higher[LVL_N];

  always_comb begin
    lvl_num = '0;
    for (int i = LVL_N - 1; i >= 0; i--) begin
      if (elig[i]) lvl_num = NUM_W'(i + 1);
    end
  end

  // two words per vector slot
  assign lvl_vec = VEC_W'({lvl_num, 1'b0});

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'(36)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_any,
  input  logic [VEC_W-1:0] lvl_vec,
  input  logic             nmi_req,
  input  logic             irq_ready,
  input  logic             gdis_wr,
  input  logic             gdis_wval,
  output logic             irq_valid,
  output logic             irq_nmi,
  output logic [VEC_W-1:0] irq_vector,
  output logic             gdis_q,
  output logic             nmi_pend_q,
  output logic             take_lvl
);

  logic hs;

  assign irq_valid  = nmi_pend_q | lvl_any;
  assign irq_nmi    = nmi_pend_q;
  assign irq_vector = nmi_pend_q ? NMI_VEC : lvl_vec;
  assign hs         = irq_valid & irq_ready;
  assign take_lvl   = hs & ~nmi_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  nmi_pend_q <= 1'b0;
    else if (nmi_req)            nmi_pend_q <= 1'b1;
    else if (hs && nmi_pend_q)   nmi_pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gdis_q <= 1'b1;
    else if (hs)      gdis_q <= 1'b1;
    else if (gdis_wr) gdis_q <= gdis_wval;
  end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int               LVL_N   = 6,
  parameter int               REG_W   = 8,
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'(36)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-1:0] lvl_req,
  input  logic             nmi_req,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic             irq_nmi,
  output logic [VEC_W-1:0] irq_vector
);

  logic             wr_flag, wr_mask, wr_gdis;
  logic [LVL_N-1:0] flag_q, mask_q, elig, grant_oh, clr_vec;
  logic [VEC_W-1:0] lvl_vec;
  logic             lvl_any, gdis_q, nmi_pend_q, take_lvl;
  logic             unused_wbits;

  assign wr_flag = reg_wr && (reg_sel == SEL_FLAG);
  assign wr_mask = reg_wr && (reg_sel == SEL_MASK);
  assign wr_gdis = reg_wr && (reg_sel == SEL_GDIS);
  assign unused_wbits = ^reg_wdata[REG_W-1:LVL_N];

  // enables are not touched by reset
  always_ff @(posedge clk) begin
    if (wr_mask) mask_q <= reg_wdata[LVL_N-1:0];
  end

  assign elig    = flag_q & mask_q & {LVL_N{~gdis_q}};
  assign clr_vec = (wr_flag ? reg_wdata[LVL_N-1:0] : '0)
                 | (take_lvl ? grant_oh : '0);

  irq_flag_bank #(.LVL_N(LVL_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (lvl_req),
    .clr_vec (clr_vec),
    .flag_q  (flag_q)
  );

  irq_prio_pick #(.LVL_N(LVL_N), .VEC_W(VEC_W)) u_pick (
    .elig     (elig),
    .grant_oh (grant_oh),
    .any      (lvl_any),
    .lvl_vec  (lvl_vec)
  );

  irq_gate_ctrl #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_any    (lvl_any),
    .lvl_vec    (lvl_vec),
    .nmi_req    (nmi_req),
    .irq_ready  (irq_ready),
    .gdis_wr    (wr_gdis),
    .gdis_wval  (reg_wdata[0]),
    .irq_valid  (irq_valid),
    .irq_nmi    (irq_nmi),
    .irq_vector (irq_vector),
    .gdis_q     (gdis_q),
    .nmi_pend_q (nmi_pend_q),
    .take_lvl   (take_lvl)
  );

  always_comb begin
    case (reg_sel)
      SEL_FLAG: reg_rdata = REG_W'(flag_q);
      SEL_MASK: reg_rdata = REG_W'(mask_q);
      SEL_GDIS: reg_rdata = REG_W'(gdis_q);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
  parameter int LVL_N = 6,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_N-1:0] lvl_req,
  input logic [LVL_N-1:0] flag_q,
  input logic [LVL_N-1:0] mask_q,
  input logic [LVL_N-1:0] grant_oh,
  input logic             gdis_q,
  input logic             nmi_pend_q,
  input logic             reg_wr,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic             irq_nmi,
  input logic [VEC_W-1:0] irq_vector
);

  // R2
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req != '0) |=> ((flag_q & $past(lvl_req)) == $past(lvl_req)));

  // R5
  offer_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_nmi) |-> (!gdis_q && ((flag_q & mask_q) != '0)));

  // R6
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));

  // R7
  vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_nmi) |-> (irq_vector[0] == 1'b0 &&
      irq_vector >= VEC_W'(2) && irq_vector <= VEC_W'(2 * LVL_N)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !irq_nmi && ((lvl_req & grant_oh) == '0))
      |=> ((flag_q & $past(grant_oh)) == '0));

  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !reg_wr) |=> irq_valid);

  // R9
  ack_gdis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> gdis_q);

  // R11
  nmi_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend_q |-> (irq_valid && irq_nmi));

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.LVL_N(LVL_N), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvl_req    (lvl_req),
  .flag_q     (flag_q),
  .mask_q     (mask_q),
  .grant_oh   (grant_oh),
  .gdis_q     (gdis_q),
  .nmi_pend_q (nmi_pend_q),
  .reg_wr     (reg_wr),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_nmi    (irq_nmi),
  .irq_vector (irq_vector)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] lvl_req = '0;
  logic       nmi_req = 1'b0;
  logic [1:0] reg_sel = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_valid;
  logic       irq_ready = 1'b0;
  logic       irq_nmi;
  logic [7:0] irq_vector;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_level_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .nmi_req(nmi_req),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_nmi(irq_nmi), .irq_vector(irq_vector)
  );

  // {request, enables, expected valid, expected vector}
  localparam logic [20:0] TV [8] = '{
    {6'b000001, 6'h3F, 1'b1, 8'h02},
    {6'b100000, 6'h3F, 1'b1, 8'h0C},
    {6'b010100, 6'h3F, 1'b1, 8'h06},
    {6'b111111, 6'h3E, 1'b1, 8'h04},
    {6'b001100, 6'h03, 1'b0, 8'h00},
    {6'b110000, 6'h20, 1'b1, 8'h0C},
    {6'b101010, 6'h08, 1'b1, 8'h08},
    {6'b000000, 6'h3F, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic pulse_req(input logic [5:0] r, input logic n);
    @(negedge clk);
    lvl_req = r; nmi_req = n;
    @(negedge clk);
    lvl_req = '0; nmi_req = 1'b0;
  endtask

  task automatic take;
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 flags after reset", v, 8'h00);
    rd(2'd2, v); chk("R1 disable after reset", v, 8'h01);
    chk("R1 no offer after reset", irq_valid, 1'b0);

    // R4 enables survive reset
    wr(2'd1, 8'h15);
    do_reset();
    rd(2'd1, v); chk("R4 enables kept over reset", v, 8'h15);

    // table walk: R2 R5 R6 R7 R8 R9
    for (int i = 0; i < 8; i++) begin
      logic [5:0] rq, mk, left;
      logic       ev;
      logic [7:0] evec;
      rq = TV[i][20:15]; mk = TV[i][14:9]; ev = TV[i][8]; evec = TV[i][7:0];
      wr(2'd1, {2'b00, mk});
      wr(2'd0, 8'h3F);
      wr(2'd2, 8'h00);
      pulse_req(rq, 1'b0);
      chk("R5 offer valid", irq_valid, ev);
      rd(2'd0, v); chk("R2 flags latched", v, {2'b00, rq});
      if (ev) begin
        chk("R6 R7 vector", irq_vector, evec);
        chk("R11 not nmi", irq_nmi, 1'b0);
        @(negedge clk);
        chk("R8 offer held", irq_valid, 1'b1);
        chk("R8 vector held", irq_vector, evec);
        take();
        left = rq & ~(6'd1 << (evec / 2 - 1));
        rd(2'd0, v); chk("R8 taken flag cleared", v, {2'b00, left});
        rd(2'd2, v); chk("R9 disable set on take", v, 8'h01);
        chk("R5 no offer while disabled", irq_valid, 1'b0);
      end
    end

    // R10 disable gating and nesting
    wr(2'd1, 8'h3F);
    wr(2'd0, 8'h3F);
    wr(2'd2, 8'h01);
    pulse_req(6'b000100, 1'b0);
    chk("R5 disable blocks offer", irq_valid, 1'b0);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R10 disable readback", v, 8'h00);
    chk("R10 offer after enable", irq_valid, 1'b1);
    chk("R7 level 3 vector", irq_vector, 8'h06);
    take();
    pulse_req(6'b000001, 1'b0);
    chk("R10 blocked inside routine", irq_valid, 1'b0);
    wr(2'd2, 8'h00);
    chk("R10 nested offer", irq_valid, 1'b1);
    chk("R10 nested vector", irq_vector, 8'h02);
    take();

    // R11 non-maskable, with enables off and disable set
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    pulse_req(6'b000000, 1'b1);
    chk("R11 nmi offered", irq_valid, 1'b1);
    chk("R11 nmi flag", irq_nmi, 1'b1);
    chk("R11 nmi vector", irq_vector, 8'h24);
    take();
    chk("R11 nmi cleared by take", irq_valid, 1'b0);

    // R11 priority over a level, level flag survives
    wr(2'd1, 8'h3F);
    wr(2'd0, 8'h3F);
    wr(2'd2, 8'h00);
    pulse_req(6'b000010, 1'b1);
    chk("R11 nmi beats level", irq_nmi, 1'b1);
    chk("R11 nmi vector first", irq_vector, 8'h24);
    take();
    rd(2'd0, v); chk("R11 level flag kept", v, 8'h02);
    chk("R9 disable after nmi take", irq_valid, 1'b0);

    // R3 clear with same-level request in the same cycle
    wr(2'd0, 8'h3F);
    pulse_req(6'b000011, 1'b0);
    @(negedge clk);
    reg_sel = 2'd0; reg_wdata = 8'h03; reg_wr = 1'b1; lvl_req = 6'b000001;
    @(negedge clk);
    reg_wr = 1'b0; lvl_req = '0;
    rd(2'd0, v); chk("R3 request beats clear", v, 8'h01);
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R3 other flags untouched", v, 8'h01);

    // R8 take with same-level request in the same cycle
    wr(2'd0, 8'h3F);
    wr(2'd2, 8'h00);
    pulse_req(6'b000100, 1'b0);
    chk("R8 offer before collision", irq_vector, 8'h06);
    irq_ready = 1'b1; lvl_req = 6'b000100;
    @(negedge clk);
    irq_ready = 1'b0; lvl_req = '0;
    rd(2'd0, v); chk("R8 request beats take clear", v, 8'h04);

    // R9 take wins over software clear of disable
    wr(2'd2, 8'h00);
    chk("R9 offer ready", irq_valid, 1'b1);
    reg_sel = 2'd2; reg_wdata = 8'h00; reg_wr = 1'b1; irq_ready = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; irq_ready = 1'b0;
    rd(2'd2, v); chk("R9 take beats software clear", v, 8'h01);

    report();
  end

endmodule